// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block keeps the coherence state of every line in one private, direct-mapped cache that shares a snooping bus with other caches. It holds a small tag and state array. Each line is invalid, shared, exclusive-clean or modified. Requests arrive from two sides. The local processor issues reads and writes. The bus shows transactions issued by other caches. From both, the block computes each line's next state, raises bus requests, drives its share of the wired-OR shared line, and strobes a flush when its copy must supply data.

A read miss fetches the line and installs it as exclusive-clean when no other cache reports a copy, so a later write by that cache upgrades locally without any bus traffic. When several caches hold a clean copy, only the sole holder of an exclusive or modified line supplies data. Shared copies never flush, so at most one cache drives data for any snooped read. The data array, arbitration between caches, the memory controller and victim write-back belong to neighbouring blocks. Those blocks hold a request until it is acknowledged and never assert a snoop in the cycle they grant this cache.

All addresses are line addresses. The low index bits select the line and the remaining bits form the tag.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After a synchronous active-low reset every line is invalid. A snooped read to any line gets `snp_shared`=0 and `snp_flush`=0, and any processor access misses.
- R2: A processor read miss raises `bus_req` one cycle later with `bus_cmd`=1 (bus read) and the request's line address. In the cycle that `bus_gnt` is high, `cpu_ack` is high. The line is then installed as shared if `bus_shared_in` was high in that cycle, and as exclusive-clean if it was low.
- R3: In the same cycle as a snooped bus read (`snp_cmd`=1) whose tag matches a valid line, `snp_shared` is high. It is low for invalid lines, tag mismatches and other commands.
- R4: A processor write to an exclusive-clean line is acknowledged in the same cycle with no bus request, and the line becomes modified.
- R5: A processor write to a shared line issues `bus_cmd`=3 (upgrade) and the line becomes modified at grant. A write to a modified line is acknowledged at once with no bus request.
- R6: A processor write miss issues `bus_cmd`=2 (read-exclusive) and the line becomes modified at grant.
- R7: A snooped bus read to a modified line strobes `snp_flush` in that cycle and demotes the line to shared. A snooped read to an exclusive-clean line demotes it to shared and flushes only when `C2C_SHARE`=1. A shared line never flushes.
- R8: A snooped read-exclusive or upgrade that hits a valid line invalidates it, and strobes `snp_flush` only if the line was modified.
- R9: While a request is pending, `cpu_ack` stays low until the grant, and `bus_req` and `bus_line` hold steady.
- R10: In a cycle with `snp_valid` high and no request pending, the processor request is not acknowledged and no bus request is launched from it. The request is evaluated in the next cycle against the state the snoop left.
- R11: A pending upgrade whose line is invalidated by a snoop before grant is turned into a read-exclusive (`bus_cmd`=2) for the same line.
- R12: A processor read that hits any valid line is acknowledged in the same cycle with no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request valid, held until acknowledged |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_line | input | LINE_W | Processor line address |
| cpu_ack | output | 1 | Request complete this cycle |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-exclusive, 3 upgrade |
| bus_line | output | LINE_W | Line address of the pending transaction |
| bus_gnt | input | 1 | Own transaction is on the bus this cycle |
| bus_shared_in | input | 1 | Wired-OR shared result during own grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| snp_line | input | LINE_W | Snooped line address |
| snp_shared | output | 1 | This cache's contribution to the wired-OR shared line |
| snp_flush | output | 1 | This cache must supply the line's data |

## Verification
A snooped transaction and a processor request can fall in the same cycle. The bench forces this by raising a processor write and a snooped read to the same exclusive-clean line together. It then checks that the write is held back, that the snoop flushes and demotes the line, and that the write later leaves as an upgrade rather than a silent local write. A snoop can also arrive while an upgrade waits for grant. The bench sends a read-exclusive to that line before granting, and checks that the pending command becomes a read-exclusive on the same line.

// File: rtl/mesi_pkg.sv
// Shared types for the coherence controller.
// Assumes a two-bit encoding for line state and bus command.
package mesi_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHD = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        BC_NONE  = 2'd0,
        BC_READ  = 2'd1,
        BC_READX = 2'd2,
        BC_UPGR  = 2'd3
    } bus_cmd_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } ctrl_phase_e;
endpackage

// File: rtl/mesi_tag_array.sv
// Direct-mapped tag and state storage with two read ports and one write port.
// Port A serves the processor and port B serves the snooper.
// Assumes the caller arbitrates the single write port.
module mesi_tag_array
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int TAG_W     = 10,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [TAG_W-1:0] rd_a_tag,
    output line_state_e      rd_a_state,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [TAG_W-1:0] rd_b_tag,
    output line_state_e      rd_b_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  line_state_e      wr_state
);
    logic [NUM_LINES-1:0][1:0]       st_vec;
    logic [NUM_LINES-1:0][TAG_W-1:0] tg_vec;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic [1:0]       st_q;
        logic [TAG_W-1:0] tg_q;
        // Per-line register: clear on reset, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= LS_INV;
                tg_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                st_q <= wr_state;
                tg_q <= wr_tag;
            end
        end
        assign st_vec[i] = st_q;
        assign tg_vec[i] = tg_q;
    end

    // Read ports: plain indexed lookup.
    always_comb begin
        rd_a_state = line_state_e'(st_vec[rd_a_idx]);
        rd_a_tag   = tg_vec[rd_a_idx];
        rd_b_state = line_state_e'(st_vec[rd_b_idx]);
        rd_b_tag   = tg_vec[rd_b_idx];
    end
endmodule

// File: rtl/mesi_snoop_logic.sv
// Reacts to one snooped bus transaction against the addressed line.
// Produces the shared-line drive, the flush strobe and the line's new state.
// Assumes line_hit already folds in tag match and validity.
// C2C_SHARE selects whether an exclusive-clean holder supplies data.
module mesi_snoop_logic
    import mesi_pkg::*;
#(
    parameter bit C2C_SHARE = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        snp_valid,
    input  bus_cmd_e    snp_cmd,
    input  logic        line_hit,
    input  line_state_e line_state,
    output logic        shared_drv,
    output logic        flush,
    output logic        upd_en,
    output line_state_e upd_state
);
    logic exc_supplies;

    if (C2C_SHARE) begin : g_c2c
        assign exc_supplies = 1'b1;
    end else begin : g_mem
        assign exc_supplies = 1'b0;
    end

    // Snoop reaction: demote on read, invalidate on exclusive request.
    always_comb begin
        shared_drv = 1'b0;
        flush      = 1'b0;
        upd_en     = 1'b0;
        upd_state  = line_state;
        if (snp_valid && line_hit) begin
            unique case (snp_cmd)
                BC_READ: begin
                    shared_drv = 1'b1;
                    if (line_state == LS_MOD) begin
                        flush     = 1'b1;
                        upd_en    = 1'b1;
                        upd_state = LS_SHD;
                    end else if (line_state == LS_EXC) begin
                        flush     = exc_supplies;
                        upd_en    = 1'b1;
                        upd_state = LS_SHD;
                    end
                end
                BC_READX, BC_UPGR: begin
                    flush     = (line_state == LS_MOD);
                    upd_en    = 1'b1;
                    upd_state = LS_INV;
                end
                default: ;
            endcase
        end
    end

    // R7
    flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (line_state == LS_MOD || line_state == LS_EXC));

    // R3
    shared_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shared_drv |-> (snp_cmd == BC_READ && line_state != LS_INV));
endmodule

// File: rtl/mesi_cpu_ctrl.sv
// Processor-side sequencer: serves hits locally, launches one bus request
// per miss or upgrade, and installs the line on grant.
// Assumes cpu_req is held until cpu_ack and snoops never coincide with grant.
module mesi_cpu_ctrl
    import mesi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic [TAG_W-1:0] cpu_tag,
    input  logic             look_hit,
    input  line_state_e      look_state,
    input  logic             snoop_busy,
    input  logic             snoop_inval,
    input  logic [IDX_W-1:0] snoop_idx,
    input  logic             bus_gnt,
    input  logic             bus_shared_in,
    output logic             cpu_ack,
    output logic             bus_req,
    output bus_cmd_e         bus_cmd,
    output logic [IDX_W-1:0] bus_idx,
    output logic [TAG_W-1:0] bus_tag,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [TAG_W-1:0] wr_tag,
    output line_state_e      wr_state
);
    ctrl_phase_e      phase_q;
    bus_cmd_e         pend_cmd_q;
    logic [IDX_W-1:0] pend_idx_q;
    logic [TAG_W-1:0] pend_tag_q;

    logic     idle, serve, local_ok, launch;
    bus_cmd_e launch_cmd;

    // Decide between local completion and a bus request.
    always_comb begin
        idle       = (phase_q == PH_IDLE);
        serve      = idle && cpu_req && !snoop_busy;
        local_ok   = look_hit && (!cpu_we || look_state == LS_EXC || look_state == LS_MOD);
        launch     = serve && !local_ok;
        launch_cmd = !cpu_we ? BC_READ : (look_hit ? BC_UPGR : BC_READX);
        cpu_ack    = idle ? (serve && local_ok) : bus_gnt;
    end

    // State-array update from a silent upgrade or from a granted fill.
    always_comb begin
        wr_en    = 1'b0;
        wr_idx   = cpu_idx;
        wr_tag   = cpu_tag;
        wr_state = LS_MOD;
        if (serve && cpu_we && look_hit && look_state == LS_EXC) begin
            wr_en = 1'b1;
        end else if (!idle && bus_gnt) begin
            wr_en    = 1'b1;
            wr_idx   = pend_idx_q;
            wr_tag   = pend_tag_q;
            wr_state = (pend_cmd_q == BC_READ) ? (bus_shared_in ? LS_SHD : LS_EXC) : LS_MOD;
        end
    end

    // Request tracking: launch, promote a lost upgrade, retire on grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            pend_cmd_q <= BC_NONE;
            pend_idx_q <= '0;
            pend_tag_q <= '0;
        end else if (launch) begin
            phase_q    <= PH_WAIT;
            pend_cmd_q <= launch_cmd;
            pend_idx_q <= cpu_idx;
            pend_tag_q <= cpu_tag;
        end else if (!idle && bus_gnt) begin
            phase_q    <= PH_IDLE;
            pend_cmd_q <= BC_NONE;
        end else if (!idle && pend_cmd_q == BC_UPGR && snoop_inval && snoop_idx == pend_idx_q) begin
            pend_cmd_q <= BC_READX;
        end
    end

    // Bus-side view of the pending request.
    always_comb begin
        bus_req = !idle;
        bus_cmd = idle ? BC_NONE : pend_cmd_q;
        bus_idx = pend_idx_q;
        bus_tag = pend_tag_q;
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_idx) && $stable(bus_tag)));

    // R10
    snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_busy && !bus_req) |=> !bus_req);

    // R11
    upg_promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && bus_cmd == BC_UPGR && snoop_inval && snoop_idx == bus_idx)
        |=> (bus_cmd == BC_READX));

    // R12
    local_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && !bus_req) |=> !bus_req);
endmodule

// File: rtl/mesi_snoop_ctrl.sv
// Top of the per-cache coherence controller.
// Splits line addresses into index and tag, looks up both sides in the
// state array, and gives snoop updates priority on the single write port.
// Assumes line addresses and external arbitration of the shared bus.
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int LINE_W    = 12,
    parameter int NUM_LINES = 4,
    parameter bit C2C_SHARE = 1'b1,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int TAG_W    = LINE_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [LINE_W-1:0] cpu_line,
    output logic              cpu_ack,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [LINE_W-1:0] bus_line,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [LINE_W-1:0] snp_line,
    output logic              snp_shared,
    output logic              snp_flush
);
    logic [IDX_W-1:0] cpu_idx, snp_idx, bus_idx, cw_idx, w_idx;
    logic [TAG_W-1:0] cpu_tag, snp_tag, bus_tag, cw_tag, w_tag;
    logic [TAG_W-1:0] a_tag, b_tag;
    line_state_e      a_state, b_state, s_upd_state, cw_state, w_state;
    logic             cpu_hit, snp_hit, s_upd_en, cw_en, w_en;
    bus_cmd_e         bus_cmd_e_w;

    // Address split for both lookup sides.
    always_comb begin
        cpu_idx = cpu_line[IDX_W-1:0];
        cpu_tag = cpu_line[LINE_W-1:IDX_W];
        snp_idx = snp_line[IDX_W-1:0];
        snp_tag = snp_line[LINE_W-1:IDX_W];
    end

    mesi_tag_array #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(cpu_idx), .rd_a_tag(a_tag), .rd_a_state(a_state),
        .rd_b_idx(snp_idx), .rd_b_tag(b_tag), .rd_b_state(b_state),
        .wr_en(w_en), .wr_idx(w_idx), .wr_tag(w_tag), .wr_state(w_state)
    );

    // Hit detection: tag match on a valid line.
    always_comb begin
        cpu_hit = (a_tag == cpu_tag) && (a_state != LS_INV);
        snp_hit = (b_tag == snp_tag) && (b_state != LS_INV);
    end

    mesi_snoop_logic #(.C2C_SHARE(C2C_SHARE)) u_snoop (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_cmd(bus_cmd_e'(snp_cmd)),
        .line_hit(snp_hit), .line_state(b_state),
        .shared_drv(snp_shared), .flush(snp_flush),
        .upd_en(s_upd_en), .upd_state(s_upd_state)
    );

    mesi_cpu_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_cpu (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_idx(cpu_idx), .cpu_tag(cpu_tag),
        .look_hit(cpu_hit), .look_state(a_state),
        .snoop_busy(snp_valid),
        .snoop_inval(s_upd_en && s_upd_state == LS_INV),
        .snoop_idx(snp_idx),
        .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
        .cpu_ack(cpu_ack), .bus_req(bus_req), .bus_cmd(bus_cmd_e_w),
        .bus_idx(bus_idx), .bus_tag(bus_tag),
        .wr_en(cw_en), .wr_idx(cw_idx), .wr_tag(cw_tag), .wr_state(cw_state)
    );

    // Write-port arbitration: a snoop update wins over the processor side.
    always_comb begin
        w_en    = s_upd_en || cw_en;
        w_idx   = s_upd_en ? snp_idx : cw_idx;
        w_tag   = s_upd_en ? b_tag : cw_tag;
        w_state = s_upd_en ? s_upd_state : cw_state;
    end

    // Bus-side outputs.
    always_comb begin
        bus_cmd  = bus_cmd_e_w;
        bus_line = {bus_tag, bus_idx};
    end

    // R4
    silent_upg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && cpu_ack && !bus_req) |=> !bus_req);
endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module mesi_snoop_ctrl_tb;
    localparam int LW = 12;
    localparam logic [LW-1:0] LN_A  = 12'h004;
    localparam logic [LW-1:0] LN_C  = 12'h001;
    localparam logic [LW-1:0] LN_D  = 12'h002;
    localparam logic [LW-1:0] LN_D2 = 12'h00A;
    localparam logic [LW-1:0] LN_E  = 12'h003;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_req = 0, cpu_we = 0, bus_gnt = 0, bus_shared_in = 0, snp_valid = 0;
    logic [LW-1:0] cpu_line = '0, snp_line = '0, bus_line;
    logic [1:0] snp_cmd = '0, bus_cmd;
    logic cpu_ack, bus_req, snp_shared, snp_flush;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mesi_snoop_ctrl #(.LINE_W(LW), .NUM_LINES(4), .C2C_SHARE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_line(cpu_line), .cpu_ack(cpu_ack), .bus_req(bus_req),
        .bus_cmd(bus_cmd), .bus_line(bus_line), .bus_gnt(bus_gnt),
        .bus_shared_in(bus_shared_in), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
        .snp_line(snp_line), .snp_shared(snp_shared), .snp_flush(snp_flush)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic snoop_probe(input logic [1:0] cmd, input logic [LW-1:0] ln,
                               input bit exp_sh, input bit exp_fl, input string req);
        @(negedge clk);
        snp_valid = 1; snp_cmd = cmd; snp_line = ln;
        #1;
        chk(snp_shared == exp_sh, {req, " shared"}, snp_shared, exp_sh);
        chk(snp_flush == exp_fl, {req, " flush"}, snp_flush, exp_fl);
        @(negedge clk);
        snp_valid = 0; snp_cmd = 0;
    endtask

    task automatic local_hit(input bit we, input logic [LW-1:0] ln, input string req);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_line = ln;
        #1;
        chk(cpu_ack == 1, {req, " ack"}, cpu_ack, 1);
        @(negedge clk);
        cpu_req = 0;
        #1;
        chk(bus_req == 0, {req, " no bus"}, bus_req, 0);
    endtask

    task automatic bus_access(input bit we, input logic [LW-1:0] ln, input logic [1:0] exp_cmd,
                              input bit shin, input int nwait, input string req);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_line = ln;
        #1;
        chk(cpu_ack == 0, {req, " no early ack"}, cpu_ack, 0);
        @(negedge clk);
        #1;
        chk(bus_req == 1, {req, " req"}, bus_req, 1);
        chk(bus_cmd == exp_cmd, {req, " cmd"}, bus_cmd, exp_cmd);
        chk(bus_line == ln, {req, " line"}, bus_line, ln);
        for (int k = 0; k < nwait; k++) begin
            @(negedge clk);
            #1;
            // R9 hold while ungranted
            chk(bus_req == 1 && bus_line == ln, "R9 held", bus_line, ln);
            chk(cpu_ack == 0, "R9 stall", cpu_ack, 0);
        end
        bus_gnt = 1; bus_shared_in = shin;
        #1;
        chk(cpu_ack == 1, {req, " ack at grant"}, cpu_ack, 1);
        @(negedge clk);
        bus_gnt = 0; bus_shared_in = 0; cpu_req = 0;
        #1;
        chk(bus_req == 0, {req, " released"}, bus_req, 0);
    endtask

    task automatic t_reset;
        snoop_probe(2'd1, LN_A, 0, 0, "R1 idle line");
        snoop_probe(2'd1, LN_E, 0, 0, "R1 idle line");
    endtask

    task automatic t_exclusive_path;
        bus_access(0, LN_A, 2'd1, 0, 2, "R2 read miss alone");
        local_hit(1, LN_A, "R4 silent write");
        snoop_probe(2'd1, LN_A, 1, 1, "R7 modified demote");
        snoop_probe(2'd1, LN_A, 1, 0, "R7 shared no flush");
        bus_access(1, LN_A, 2'd3, 0, 1, "R5 upgrade");
        local_hit(1, LN_A, "R5 write on modified");
        snoop_probe(2'd2, LN_A, 0, 1, "R8 readx on modified");
        snoop_probe(2'd1, LN_A, 0, 0, "R8 now invalid");
    endtask

    task automatic t_shared_path;
        bus_access(0, LN_C, 2'd1, 1, 0, "R2 read miss shared");
        local_hit(0, LN_C, "R12 read hit");
        snoop_probe(2'd1, LN_C, 1, 0, "R3 shared copy");
        snoop_probe(2'd3, LN_C, 0, 0, "R8 upgrade on shared");
        snoop_probe(2'd1, LN_C, 0, 0, "R8 shared gone");
    endtask

    task automatic t_supplier;
        bus_access(0, LN_D, 2'd1, 0, 0, "R2 fill exclusive");
        snoop_probe(2'd1, LN_D, 1, 1, "R7 exclusive supplies");
        bus_access(1, LN_D, 2'd3, 0, 0, "R7 left shared");
        snoop_probe(2'd1, LN_D2, 0, 0, "R3 tag mismatch");
        snoop_probe(2'd1, LN_D, 1, 1, "R3 mismatch left line");
    endtask

    task automatic t_write_miss;
        bus_access(1, LN_E, 2'd2, 1, 1, "R6 write miss");
        snoop_probe(2'd1, LN_E, 1, 1, "R6 now modified");
    endtask

    task automatic t_same_cycle;
        bus_access(0, LN_A, 2'd1, 0, 0, "R10 setup");
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_line = LN_A;
        snp_valid = 1; snp_cmd = 2'd1; snp_line = LN_A;
        #1;
        chk(cpu_ack == 0, "R10 held back", cpu_ack, 0);
        chk(snp_flush == 1, "R7 flush same cycle", snp_flush, 1);
        @(negedge clk);
        snp_valid = 0; snp_cmd = 0;
        #1;
        chk(cpu_ack == 0, "R10 no silent write", cpu_ack, 0);
        chk(bus_req == 0, "R10 no launch in snoop cycle", bus_req, 0);
        @(negedge clk);
        #1;
        chk(bus_req == 1 && bus_cmd == 2'd3, "R10 upgrade after snoop", bus_cmd, 3);
        bus_gnt = 1;
        #1;
        chk(cpu_ack == 1, "R10 ack at grant", cpu_ack, 1);
        @(negedge clk);
        bus_gnt = 0; cpu_req = 0;
    endtask

    task automatic t_lost_upgrade;
        snoop_probe(2'd1, LN_A, 1, 1, "R11 setup modified");
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_line = LN_A;
        @(negedge clk);
        #1;
        chk(bus_cmd == 2'd3, "R11 upgrade pending", bus_cmd, 3);
        snp_valid = 1; snp_cmd = 2'd2; snp_line = LN_A;
        #1;
        chk(snp_flush == 0, "R8 shared invalidated silently", snp_flush, 0);
        @(negedge clk);
        snp_valid = 0; snp_cmd = 0;
        #1;
        chk(bus_cmd == 2'd2, "R11 promoted", bus_cmd, 2);
        chk(bus_line == LN_A, "R11 same line", bus_line, LN_A);
        bus_gnt = 1;
        #1;
        chk(cpu_ack == 1, "R11 ack", cpu_ack, 1);
        @(negedge clk);
        bus_gnt = 0; cpu_req = 0;
        snoop_probe(2'd1, LN_A, 1, 1, "R11 ends modified");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(bus_req == 0 && cpu_ack == 0, "R1 reset outputs", bus_req, 0);
        rst_n = 1;
        t_reset();
        t_exclusive_path();
        t_shared_path();
        t_supplier();
        t_write_miss();
        t_same_cycle();
        t_lost_upgrade();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule